// File: doc/BRIEF.md
# Trap Abort and Drain Controller

This block sits beside the issue logic of an out-of-order core built from independent functional units (FUs). Any FU that meets an exceptional condition raises its own trigger bit. The controller merges those bits into one abort line, which every FU treats as a command to drop its in-flight work and return to idle. Nothing is rolled back. On the clock edge that ends the trigger cycle, the controller writes the trap status, trap PC and trap cause registers together and moves the core to machine privilege.

An external interrupt is handled more gently. If the global interrupt enable is set, issue is halted and the controller waits for every FU to report not-busy. It then performs the same bulk register update, recording the resume PC and marking the cause as an interrupt. In the cycle after any trap entry, issue resumes with a one-cycle redirect to the handler.

The whole CSR space is treated as one dependency. A single token goes to at most one FU at a time. It is withdrawn on abort and is not handed out while an interrupt drain is in progress. A return request drops the core back to user privilege and re-enables interrupts.

Top module: `trap_ctrl`

## Requirements
- R1: `abort_o` is high in exactly the cycles in which at least one bit of `fu_event_i` is high.
- R2: In the cycle after an abort, `trap_pc_o` holds the PC that came with the lowest-index triggering FU, and `trap_cause_o` holds that FU's 4-bit code with bit 4 clear.
- R3: Every bulk update leaves `priv_o` = 1 (machine) and rewrites `trap_status_o` as bit 0 interrupt enable = 0, bit 1 = the previous interrupt enable, and bit 2 = the previous privilege.
- R4: `issue_en_o` is low in every abort cycle. It is high in the cycle after a trap entry, and in that same cycle `redirect_valid_o` is high for exactly one cycle.
- R5: An accepted interrupt drives `issue_en_o` low from the next cycle. No trap entry happens while any bit of `fu_busy_i` is set. The entry happens on the edge where `fu_busy_i` is zero, and it records `resume_pc_i` and the cause {1, `irq_code_i`}.
- R6: While status bit 0 is clear, `irq_i` is ignored: `issue_en_o` stays high and the trap registers do not change.
- R7: A trigger that arrives during an interrupt drain takes precedence. The recorded cause is the FU's code with bit 4 clear.
- R8: While `redirect_valid_o` is high, `redirect_pc_o` equals HANDLER_BASE for an exception, and HANDLER_BASE + 4 × code for an interrupt.
- R9: `trap_return_i`, taken outside a drain and in a cycle with no trigger, gives `priv_o` = 0 and status bit 0 = 1 in the next cycle. Status bits 1 and 2, the trap PC and the trap cause are left unchanged.
- R10: `csr_grant_o` is zero or one-hot. When no FU holds the token, it goes in the next cycle to the lowest-index FU in `csr_req_i`. The holder keeps it for as long as its request stays high.
- R11: `csr_grant_o` is zero in the cycle after an abort, and no new grant is made during a drain.
- R12: After reset: `issue_en_o` = 1, `priv_o` = 1, `redirect_valid_o` = 0, and the status, PC, cause and grant outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fu_event_i | input | N_FU | Per-FU exception trigger |
| fu_pc_i | input | N_FU*XLEN | PC supplied with each FU's trigger |
| fu_code_i | input | N_FU*CODE_W | Cause code supplied with each FU's trigger |
| fu_busy_i | input | N_FU | Per-FU busy flag |
| irq_i | input | 1 | Interrupt pending |
| irq_code_i | input | CODE_W | Interrupt cause code |
| resume_pc_i | input | XLEN | PC at which to resume after the interrupt |
| trap_return_i | input | 1 | Return from handler to user level |
| csr_req_i | input | N_FU | Per-FU request for the CSR token |
| issue_en_o | output | 1 | Instruction issue allowed |
| abort_o | output | 1 | Global FU abort |
| redirect_valid_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | XLEN | Handler address |
| trap_status_o | output | 3 | {prev priv, prev irq enable, irq enable} |
| trap_pc_o | output | XLEN | Trap PC register |
| trap_cause_o | output | CODE_W+1 | {interrupt flag, code} |
| priv_o | output | 1 | 1 = machine, 0 = user |
| csr_grant_o | output | N_FU | CSR token holder |

## Verification
`abort_o` and the drop of `issue_en_o` on a trigger are combinational, so they are sampled in the trigger cycle itself. The trap registers, `priv_o`, the redirect strobe and the CSR grant each lie one register away from their cause, so they are compared one edge after the stimulus. An accepted interrupt lowers issue one edge later and enters only on the edge where the busy vector is zero. The bench drives its inputs just after the falling edge, compares all outputs 2 ns later against a reference model that holds the pre-edge state, and only then advances that model. This puts every check in the correct cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_REDIR = 2'd2
  } trap_state_e;

  // status register bit positions (fixed: neighbours decode them)
  localparam int unsigned STAT_IE    = 0;
  localparam int unsigned STAT_PIE   = 1;
  localparam int unsigned STAT_PPRIV = 2;
  localparam int unsigned STAT_W     = 3;

  localparam logic PRIV_USER = 1'b0;
  localparam logic PRIV_MACH = 1'b1;
endpackage

// File: rtl/trap_pick.sv
// Lowest-index-first picker: unary in, at most one bit out.
module trap_pick #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] gnt
);
  logic [WIDTH:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gnt[i]    = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
endmodule

// File: rtl/trap_select.sv
// AND-OR mux of per-FU PC and code under a one-hot select.
module trap_select #(
  parameter int unsigned N_FU   = 4,
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 4
) (
  input  logic [N_FU-1:0]        sel,
  input  logic [N_FU*XLEN-1:0]   pcs,
  input  logic [N_FU*CODE_W-1:0] codes,
  output logic [XLEN-1:0]        pc,
  output logic [CODE_W-1:0]      code
);
  always_comb begin
    pc   = '0;
    code = '0;
    for (int i = 0; i < N_FU; i++) begin
      pc   = pc   | (pcs[i*XLEN +: XLEN]       & {XLEN{sel[i]}});
      code = code | (codes[i*CODE_W +: CODE_W] & {CODE_W{sel[i]}});
    end
  end
endmodule

// File: rtl/trap_csr_token.sv
// Single token covering the whole CSR space.
module trap_csr_token #(
  parameter int unsigned N_FU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_FU-1:0] req,
  input  logic            abort,
  input  logic            hold_off,
  output logic [N_FU-1:0] owner
);
  logic [N_FU-1:0] pick_gnt;
  logic [N_FU-1:0] owner_n;
  logic            owner_en;

  trap_pick #(.WIDTH(N_FU)) u_pick (
    .req (req),
    .gnt (pick_gnt)
  );

  always_comb begin
    owner_n = owner;
    if (abort) begin
      owner_n = '0;
    end else if (|owner) begin
      if (~|(owner & req)) owner_n = '0;
    end else if (!hold_off) begin
      owner_n = pick_gnt;
    end
  end

  assign owner_en = (owner_n != owner);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner <= '0;
    end else if (owner_en) begin
      owner <= owner_n;
    end
  end
endmodule

// File: rtl/trap_seq.sv
// Run / drain / redirect sequencer plus the trap register file.
module trap_seq
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                event_any,
  input  logic [XLEN-1:0]     ev_pc,
  input  logic [CODE_W-1:0]   ev_code,
  input  logic                busy_any,
  input  logic                irq,
  input  logic [CODE_W-1:0]   irq_code,
  input  logic [XLEN-1:0]     resume_pc,
  input  logic                trap_ret,
  output trap_state_e         state,
  output logic                priv,
  output logic [STAT_W-1:0]   status,
  output logic [XLEN-1:0]     tpc,
  output logic [CODE_W:0]     tcause
);
  trap_state_e         state_n;
  logic                priv_n;
  logic [STAT_W-1:0]   status_n;
  logic [XLEN-1:0]     tpc_n;
  logic [CODE_W:0]     tcause_n;
  logic                bulk;
  logic                from_irq;
  logic                ret_take;
  logic                csr_en;

  always_comb begin
    state_n  = state;
    priv_n   = priv;
    status_n = status;
    tpc_n    = tpc;
    tcause_n = tcause;
    bulk     = 1'b0;
    from_irq = 1'b0;
    ret_take = 1'b0;

    case (state)
      ST_DRAIN: begin
        if (event_any) begin
          bulk = 1'b1;
        end else if (!busy_any) begin
          bulk     = 1'b1;
          from_irq = 1'b1;
        end
      end
      default: begin
        if (event_any) begin
          bulk = 1'b1;
        end else if (trap_ret) begin
          ret_take = 1'b1;
          state_n  = ST_RUN;
        end else if (irq && status[STAT_IE]) begin
          state_n = ST_DRAIN;
        end else begin
          state_n = ST_RUN;
        end
      end
    endcase

    if (ret_take) begin
      priv_n             = PRIV_USER;
      status_n[STAT_IE]  = 1'b1;
    end

    if (bulk) begin
      state_n              = ST_REDIR;
      priv_n               = PRIV_MACH;
      status_n[STAT_PPRIV] = priv;
      status_n[STAT_PIE]   = status[STAT_IE];
      status_n[STAT_IE]    = 1'b0;
      tpc_n                = from_irq ? resume_pc : ev_pc;
      tcause_n             = from_irq ? {1'b1, irq_code} : {1'b0, ev_code};
    end
  end

  assign csr_en = bulk | ret_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
    end else begin
      state <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv   <= PRIV_MACH;
      status <= '0;
    end else if (csr_en) begin
      priv   <= priv_n;
      status <= status_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpc    <= '0;
      tcause <= '0;
    end else if (bulk) begin
      tpc    <= tpc_n;
      tcause <= tcause_n;
    end
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned     N_FU         = 4,
  parameter int unsigned     XLEN         = 32,
  parameter int unsigned     CODE_W       = 4,
  parameter logic [XLEN-1:0] HANDLER_BASE = 32'h0000_0100
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_FU-1:0]          fu_event_i,
  input  logic [N_FU*XLEN-1:0]     fu_pc_i,
  input  logic [N_FU*CODE_W-1:0]   fu_code_i,
  input  logic [N_FU-1:0]          fu_busy_i,
  input  logic                     irq_i,
  input  logic [CODE_W-1:0]        irq_code_i,
  input  logic [XLEN-1:0]          resume_pc_i,
  input  logic                     trap_return_i,
  input  logic [N_FU-1:0]          csr_req_i,
  output logic                     issue_en_o,
  output logic                     abort_o,
  output logic                     redirect_valid_o,
  output logic [XLEN-1:0]          redirect_pc_o,
  output logic [STAT_W-1:0]        trap_status_o,
  output logic [XLEN-1:0]          trap_pc_o,
  output logic [CODE_W:0]          trap_cause_o,
  output logic                     priv_o,
  output logic [N_FU-1:0]          csr_grant_o
);
  localparam int unsigned VEC_SHIFT = 2;

  logic [1:0]          rst_sync;
  logic                rst_n;
  logic [N_FU-1:0]     ev_sel;
  logic [XLEN-1:0]     ev_pc;
  logic [CODE_W-1:0]   ev_code;
  trap_state_e         state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n = rst_sync[1];

  assign abort_o = |fu_event_i;

  trap_pick #(.WIDTH(N_FU)) u_ev_pick (
    .req (fu_event_i),
    .gnt (ev_sel)
  );

  trap_select #(.N_FU(N_FU), .XLEN(XLEN), .CODE_W(CODE_W)) u_ev_sel (
    .sel   (ev_sel),
    .pcs   (fu_pc_i),
    .codes (fu_code_i),
    .pc    (ev_pc),
    .code  (ev_code)
  );

  trap_seq #(.XLEN(XLEN), .CODE_W(CODE_W)) u_seq (
    .clk       (clk_i),
    .rst_n     (rst_n),
    .event_any (abort_o),
    .ev_pc     (ev_pc),
    .ev_code   (ev_code),
    .busy_any  (|fu_busy_i),
    .irq       (irq_i),
    .irq_code  (irq_code_i),
    .resume_pc (resume_pc_i),
    .trap_ret  (trap_return_i),
    .state     (state),
    .priv      (priv_o),
    .status    (trap_status_o),
    .tpc       (trap_pc_o),
    .tcause    (trap_cause_o)
  );

  trap_csr_token #(.N_FU(N_FU)) u_token (
    .clk      (clk_i),
    .rst_n    (rst_n),
    .req      (csr_req_i),
    .abort    (abort_o),
    .hold_off (state == ST_DRAIN),
    .owner    (csr_grant_o)
  );

  assign issue_en_o       = (state != ST_DRAIN) && !abort_o;
  assign redirect_valid_o = (state == ST_REDIR);

  always_comb begin
    if (trap_cause_o[CODE_W]) begin
      redirect_pc_o = HANDLER_BASE + (XLEN'(trap_cause_o[CODE_W-1:0]) << VEC_SHIFT);
    end else begin
      redirect_pc_o = HANDLER_BASE;
    end
  end
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter int unsigned N_FU   = 4
) (
  input logic            clk_i,
  input logic            rst_n,
  input logic            abort_o,
  input logic            issue_en_o,
  input logic            redirect_valid_o,
  input logic            priv_o,
  input logic [2:0]      trap_status_o,
  input logic [N_FU-1:0] fu_busy_i,
  input logic            trap_return_i,
  input logic [N_FU-1:0] csr_grant_o
);
  // R3
  bulk_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    abort_o |=> (priv_o && !trap_status_o[0]));

  // R4
  abort_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    abort_o |-> !issue_en_o);

  // R5
  drain_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!issue_en_o && !abort_o && (|fu_busy_i)) |=> !redirect_valid_o);

  // R8
  redirect_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    redirect_valid_o |-> priv_o);

  // R9
  return_user_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (trap_return_i && issue_en_o) |=> (!priv_o && trap_status_o[0]));

  // R10
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(csr_grant_o));

  // R11
  grant_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    abort_o |=> (csr_grant_o == '0));
endmodule

bind trap_ctrl trap_ctrl_chk #(.N_FU(N_FU)) u_chk (
  .clk_i            (clk_i),
  .rst_n            (rst_n),
  .abort_o          (abort_o),
  .issue_en_o       (issue_en_o),
  .redirect_valid_o (redirect_valid_o),
  .priv_o           (priv_o),
  .trap_status_o    (trap_status_o),
  .fu_busy_i        (fu_busy_i),
  .trap_return_i    (trap_return_i),
  .csr_grant_o      (csr_grant_o)
);

// File: tb/tb_trap_ctrl.sv
module tb_trap_ctrl;
  localparam int N  = 4;
  localparam int XL = 32;
  localparam int CW = 4;
  localparam logic [XL-1:0] BASE = 32'h0000_0100;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic [N-1:0]    fu_event, fu_busy, csr_req;
  logic [N*XL-1:0] fu_pc;
  logic [N*CW-1:0] fu_code;
  logic            irq, tret;
  logic [CW-1:0]   irq_code;
  logic [XL-1:0]   resume_pc;
  logic            issue_en, abort, rvalid, priv;
  logic [XL-1:0]   rpc, tpc;
  logic [2:0]      tstat;
  logic [CW:0]     tcause;
  logic [N-1:0]    grant;

  trap_ctrl #(.N_FU(N), .XLEN(XL), .CODE_W(CW), .HANDLER_BASE(BASE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fu_event_i(fu_event), .fu_pc_i(fu_pc),
    .fu_code_i(fu_code), .fu_busy_i(fu_busy), .irq_i(irq), .irq_code_i(irq_code),
    .resume_pc_i(resume_pc), .trap_return_i(tret), .csr_req_i(csr_req),
    .issue_en_o(issue_en), .abort_o(abort), .redirect_valid_o(rvalid),
    .redirect_pc_o(rpc), .trap_status_o(tstat), .trap_pc_o(tpc),
    .trap_cause_o(tcause), .priv_o(priv), .csr_grant_o(grant)
  );

  int total = 0;
  int bad   = 0;

  // reference model state: 0 run, 1 drain, 2 redirect
  int           m_st;
  logic         m_priv;
  logic [2:0]   m_stat;
  logic [XL-1:0] m_pc;
  logic [CW:0]  m_cause;
  logic [N-1:0] m_own;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int lowest(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [XL-1:0] exp_rpc();
    if (m_cause[CW]) return BASE + {m_cause[CW-1:0], 2'b00};
    return BASE;
  endfunction

  task automatic compare();
    chk("R1", "abort", abort, |fu_event);
    chk((m_st == 1) ? "R5" : "R4", "issue_en", issue_en, (m_st != 1) && !(|fu_event));
    chk("R4", "redirect_valid", rvalid, m_st == 2);
    if (m_st == 2) chk("R8", "redirect_pc", rpc, exp_rpc());
    chk("R2", "trap_pc", tpc, m_pc);
    chk("R2", "trap_cause", tcause, m_cause);
    chk("R3", "priv", priv, m_priv);
    chk("R3", "status", tstat, m_stat);
    chk("R10", "grant", grant, m_own);
  endtask

  task automatic bulk(logic [XL-1:0] pc, logic [CW:0] cause);
    m_stat  = {m_priv, m_stat[0], 1'b0};
    m_priv  = 1'b1;
    m_pc    = pc;
    m_cause = cause;
    m_st    = 2;
  endtask

  task automatic model_next();
    int k;
    int cur;
    cur = m_st;
    k = lowest(fu_event);
    // CSR token
    if (k >= 0) m_own = '0;
    else if (m_own != 0) begin
      if ((m_own & csr_req) == 0) m_own = '0;
    end else if (cur != 1) begin
      m_own = '0;
      if (lowest(csr_req) >= 0) m_own[lowest(csr_req)] = 1'b1;
    end
    // sequencer
    if (k >= 0) bulk(fu_pc[k*XL +: XL], {1'b0, fu_code[k*CW +: CW]});
    else if (cur == 1) begin
      if (fu_busy == 0) bulk(resume_pc, {1'b1, irq_code});
    end else if (tret) begin
      m_priv = 1'b0; m_stat[0] = 1'b1; m_st = 0;
    end else if (irq && m_stat[0]) m_st = 1;
    else m_st = 0;
  endtask

  task automatic cyc();
    #2;
    compare();
    model_next();
    @(negedge clk);
  endtask

  task automatic idle();
    fu_event = '0; fu_busy = '0; csr_req = '0; irq = 1'b0; tret = 1'b0;
    irq_code = '0; resume_pc = '0;
    for (int i = 0; i < N; i++) begin
      fu_pc[i*XL +: XL]   = 32'h1000 + 32'(i) * 32'h40;
      fu_code[i*CW +: CW] = CW'(i + 3);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog act=timeout exp=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    rst_n = 1'b0;
    m_st = 0; m_priv = 1'b1; m_stat = '0; m_pc = '0; m_cause = '0; m_own = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    #1;
    chk("R12", "issue_en", issue_en, 1);
    chk("R12", "priv", priv, 1);
    chk("R12", "status", tstat, 0);
    chk("R12", "pc", tpc, 0);
    chk("R12", "cause", tcause, 0);
    chk("R12", "grant", grant, 0);
    chk("R12", "redirect_valid", rvalid, 0);
    cyc();

    // R2 simultaneous triggers on FU1 and FU3: FU1 wins
    fu_event = 4'b1010;
    cyc();
    idle();
    #1;
    chk("R2", "lowest pc", tpc, 32'h1040);
    chk("R2", "lowest cause", tcause, 5'h04);
    chk("R8", "exception handler", rpc, BASE);
    cyc();

    // R6 interrupt with enable clear is ignored
    irq = 1'b1; irq_code = 4'h5;
    cyc();
    #1;
    chk("R6", "issue_en after masked irq", issue_en, 1);
    chk("R6", "cause unchanged", tcause, 5'h04);
    cyc();
    idle();

    // R9 return to user level
    tret = 1'b1;
    cyc();
    idle();
    #1;
    chk("R9", "priv user", priv, 0);
    chk("R9", "ie set", tstat[0], 1);
    chk("R9", "pc unchanged", tpc, 32'h1040);

    // R10 token to lowest requester
    csr_req = 4'b0110;
    cyc();
    #1;
    chk("R10", "grant lowest", grant, 4'b0010);

    // R5 interrupt drain with a busy FU
    irq = 1'b1; irq_code = 4'h3; resume_pc = 32'h2222_0000; fu_busy = 4'b0100;
    cyc();
    irq = 1'b0;
    csr_req = 4'b0100; // holder drops: no regrant while draining
    for (int j = 0; j < 3; j++) begin
      #1;
      chk("R5", "issue held low", issue_en, 0);
      chk("R5", "no entry while busy", rvalid, 0);
      cyc();
    end
    #1;
    chk("R11", "no grant in drain", grant, 0);
    fu_busy = '0;
    cyc();
    #1;
    chk("R5", "irq entry pc", tpc, 32'h2222_0000);
    chk("R5", "irq entry cause", tcause, 5'h13);
    chk("R8", "vectored handler", rpc, BASE + 32'h0c);
    chk("R4", "issue back", issue_en, 1);
    cyc();
    idle();

    // R7 trigger during drain wins
    tret = 1'b1; cyc(); tret = 1'b0;
    irq = 1'b1; fu_busy = 4'b0001; resume_pc = 32'h3333_0000; cyc();
    irq = 1'b0; cyc();
    fu_event = 4'b0100; csr_req = 4'b0001; cyc();
    idle();
    #1;
    chk("R7", "cause from FU", tcause, 5'h05);
    chk("R11", "grant after abort", grant, 0);
    cyc();

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      fu_event = (($urandom % 10) == 0) ? N'($urandom) : '0;
      fu_busy  = N'($urandom & $urandom);
      irq      = (($urandom % 5) == 0);
      tret     = (($urandom % 7) == 0);
      irq_code = CW'($urandom);
      resume_pc = $urandom;
      if (($urandom % 4) == 0) csr_req = N'($urandom);
      for (int i = 0; i < N; i++) begin
        fu_pc[i*XL +: XL]   = $urandom;
        fu_code[i*CW +: CW] = CW'($urandom);
      end
      cyc();
    end

    summary();
    $finish;
  end
endmodule